// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Engine

This block is one channel of a descriptor-driven DMA engine. Software builds a chain of four-word descriptors in a shared descriptor RAM. Each descriptor holds a next-descriptor pointer, a buffer pointer, a buffer length and a mode/status word. Software then hands the chain to the channel by writing the address of the first descriptor to the head register. The channel reads each descriptor and checks that hardware owns it. It then steps through the buffer, one byte address per cycle, for the packet length held in the mode word. After that it writes the mode word back with ownership returned to software, and follows the next pointer.

When the next pointer is zero, the channel marks that descriptor as the end of the queue, publishes it in the completion register and goes idle until the head register is written again. Software confirms each finished descriptor by writing its address into the completion register. A teardown strobe stops the channel at once. The descriptor in flight is handed back with its teardown-complete flag set, and the completion register takes a fixed sentinel value. The byte stepping stands in for the data mover. The packet path itself is not part of the block.

Top module: `ldesc_channel`

## Requirements
- R1: After reset the channel is idle (`busy` low), issues no memory request, holds `complPtr` at zero and keeps `doneEvt` low.
- R2: While idle with `enable` high, writing a nonzero address to the head register starts a fetch of four consecutive words at that address plus 0, 4, 8 and 12. Descriptors sit on 16-byte boundaries. Writing zero cancels a pending head and leaves the channel idle.
- R3: With `enable` low the channel stays idle and issues no reads, even when a head address is pending. The pending chain starts once `enable` is raised.
- R4: The word at offset 12 is the mode word. The packet length is its bits 10:0. For a length of N the channel asserts `xferValid` on N cycles, and `xferPtr` runs from the buffer pointer (offset 4) upward by one per pulse.
- R5: A finished descriptor has its mode word rewritten at offset 12. Owner bit 29 is cleared and all other bits are kept. `complPtr` then holds the descriptor address, and `doneEvt` pulses for one cycle in the cycle after that write.
- R6: A nonzero next pointer (offset 0) makes the channel fetch the next descriptor with no software action. A zero next pointer makes the channel also set end-of-queue bit 28 in that descriptor's written-back mode word, and then go idle.
- R7: A fetched descriptor whose owner bit 29 is clear is not processed. There is no byte stepping, no mode write and no `doneEvt`, and the channel returns to idle.
- R8: A `tearReq` pulse while a descriptor is being stepped stops the stepping. It rewrites that descriptor's mode word with owner bit 29 cleared and teardown-complete bit 27 set, loads `complPtr` with 0xFFFFFFFC and returns to idle with no head pending.
- R9: A `tearReq` pulse while idle loads `complPtr` with 0xFFFFFFFC and writes nothing to memory.
- R10: A software write to the completion register appears on `complPtr` in the next cycle. A hardware update in the same cycle takes precedence.
- R11: A head-register write while the channel is busy is ignored. It neither redirects the running chain nor leaves a pending start behind.
- R12: A descriptor with a length of zero produces no `xferValid` pulse but is still written back and signalled with `doneEvt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global enable; gates leaving idle |
| headWrEn | input | 1 | Head register write strobe |
| headWrData | input | 32 | Address of first descriptor (0 cancels) |
| complWrEn | input | 1 | Completion register write strobe (software acknowledge) |
| complWrData | input | 32 | Value written to the completion register |
| tearReq | input | 1 | Teardown command strobe |
| memReq | output | 1 | Descriptor RAM access request |
| memWe | output | 1 | Write enable for the access |
| memAddr | output | AW (16) | Byte address of the access |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid the cycle after a read request |
| complPtr | output | 32 | Completion register |
| xferValid | output | 1 | One buffer byte moved this cycle |
| xferPtr | output | 32 | Buffer address of the byte being moved |
| doneEvt | output | 1 | One-cycle completion event after a writeback |
| busy | output | 1 | Channel is not idle |

## Verification
The assertions assume a descriptor RAM that accepts every request in the cycle it is made and returns read data exactly one cycle later. They also assume every descriptor address lies on a 16-byte boundary, so the four fetch reads never wrap in the low address bits. The bench's memory model answers with that fixed latency. Every head address and next pointer the bench uses is a multiple of 16. Head writes, acknowledges and teardown pulses are applied at falling edges and last one cycle, so no strobe is ever held across two rising edges.

// File: rtl/ldesc_pkg.sv
package ldesc_pkg;

  localparam int DESC_WORDS = 4;
  localparam int OWN_BIT    = 29;
  localparam int EOQ_BIT    = 28;
  localparam int TDC_BIT    = 27;
  localparam logic [31:0] TEAR_SENTINEL = 32'hFFFF_FFFC;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_XFER,
    ST_WBACK,
    ST_NEXT,
    ST_TDOWN
  } chState_t;

  typedef struct packed {
    logic fetchClr;
    logic fetchOn;
    logic followNext;
    logic xferStep;
    logic wbMode;
    logic tdMode;
    logic takeHead;
  } chStrb_t;

endpackage

// File: rtl/ldesc_ctrl.sv
module ldesc_ctrl
  import ldesc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    tearReq,
  input  logic    headPend,
  input  logic    fetchDone,
  input  logic    ownerNow,
  input  logic    remZero,
  input  logic    nextZero,
  output chStrb_t strb,
  output logic    busy,
  output logic    doneEvt
);

  chState_t state, stateNxt;
  logic     tdPend;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        if (tdPend) begin
          stateNxt = ST_TDOWN;
        end else if (enable && headPend) begin
          stateNxt      = ST_FETCH;
          strb.fetchClr = 1'b1;
          strb.takeHead = 1'b1;
        end
      end
      ST_FETCH: begin
        strb.fetchOn = 1'b1;
        if (fetchDone) begin
          if (!ownerNow)   stateNxt = ST_IDLE;
          else if (tdPend) stateNxt = ST_TDOWN;
          else             stateNxt = ST_XFER;
        end
      end
      ST_XFER: begin
        if (tdPend)       stateNxt = ST_TDOWN;
        else if (remZero) stateNxt = ST_WBACK;
        else              strb.xferStep = 1'b1;
      end
      ST_WBACK: begin
        strb.wbMode = 1'b1;
        stateNxt    = ST_NEXT;
      end
      ST_NEXT: begin
        if (tdPend) begin
          stateNxt = ST_TDOWN;
        end else if (nextZero) begin
          stateNxt = ST_IDLE;
        end else begin
          stateNxt        = ST_FETCH;
          strb.fetchClr   = 1'b1;
          strb.followNext = 1'b1;
        end
      end
      ST_TDOWN: begin
        strb.tdMode = 1'b1;
        stateNxt    = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      tdPend <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == ST_TDOWN) tdPend <= tearReq;
      else                   tdPend <= tdPend | tearReq;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign doneEvt = (state == ST_NEXT);

  // R3: no fetch may begin while the global enable is low
  p_enable_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !enable) |=> (state != ST_FETCH));

  // R8: a pending teardown during stepping is taken on the next edge
  p_tear_taken_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_XFER && tdPend) |=> (state == ST_TDOWN));

endmodule

// File: rtl/ldesc_dpath.sv
module ldesc_dpath
  import ldesc_pkg::*;
#(
  parameter int AW   = 16,
  parameter int LENW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  chStrb_t       strb,
  input  logic          busy,
  input  logic          headWrEn,
  input  logic [31:0]   headWrData,
  input  logic          complWrEn,
  input  logic [31:0]   complWrData,
  input  logic [31:0]   memRdata,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  output logic [31:0]   complPtr,
  output logic          xferValid,
  output logic [31:0]   xferPtr,
  output logic          headPend,
  output logic          fetchDone,
  output logic          ownerNow,
  output logic          remZero,
  output logic          nextZero
);

  localparam int FC_W = $clog2(DESC_WORDS + 1);
  localparam logic [FC_W-1:0] FC_LAST = FC_W'(DESC_WORDS);
  localparam logic [AW-1:0]   MODE_OFS = AW'((DESC_WORDS - 1) * 4);

  logic [AW-1:0]   baseAddr;
  logic [FC_W-1:0] fc;
  logic [31:0]     nextW, bufW, modeW, complR, ptrR;
  logic [LENW-1:0] rem;
  logic            live, headR;
  logic            rdGo, wrGo;
  logic [31:0]     wbData, tdData;

  assign rdGo      = strb.fetchOn && (fc < FC_LAST);
  assign wrGo      = strb.wbMode || (strb.tdMode && live);
  assign fetchDone = (fc == FC_LAST);
  assign ownerNow  = memRdata[OWN_BIT];
  assign remZero   = (rem == '0);
  assign nextZero  = (nextW == 32'd0);

  always_comb begin
    wbData          = modeW;
    wbData[OWN_BIT] = 1'b0;
    if (nextZero) wbData[EOQ_BIT] = 1'b1;
    tdData          = modeW;
    tdData[OWN_BIT] = 1'b0;
    tdData[TDC_BIT] = 1'b1;
  end

  always_comb begin
    memReq   = rdGo || wrGo;
    memWe    = wrGo;
    memAddr  = baseAddr;
    memWdata = '0;
    if (rdGo) begin
      memAddr = baseAddr + AW'({fc, 2'b00});
    end else if (wrGo) begin
      memAddr  = baseAddr + MODE_OFS;
      memWdata = strb.wbMode ? wbData : tdData;
    end
  end

  // head register and fetch sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      headR    <= 1'b0;
      fc       <= '0;
    end else begin
      if (strb.takeHead || strb.tdMode) begin
        headR <= 1'b0;
      end else if (headWrEn && !busy) begin
        if (headWrData != 32'd0) begin
          baseAddr <= headWrData[AW-1:0];
          headR    <= 1'b1;
        end else begin
          headR <= 1'b0;
        end
      end
      if (strb.followNext) baseAddr <= nextW[AW-1:0];
      if (strb.fetchClr)                         fc <= '0;
      else if (strb.fetchOn && fc != FC_LAST)    fc <= fc + 1'b1;
    end
  end

  // captured descriptor words, byte stepping and completion register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextW  <= '0;
      bufW   <= '0;
      modeW  <= '0;
      rem    <= '0;
      ptrR   <= '0;
      live   <= 1'b0;
      complR <= '0;
    end else begin
      if (strb.fetchOn) begin
        unique case (fc)
          FC_W'(1): nextW <= memRdata;
          FC_W'(2): bufW  <= memRdata;
          FC_LAST: begin
            modeW <= memRdata;
            rem   <= memRdata[LENW-1:0];
            ptrR  <= bufW;
            live  <= memRdata[OWN_BIT];
          end
          default: ;
        endcase
      end
      if (strb.xferStep) begin
        rem  <= rem - 1'b1;
        ptrR <= ptrR + 32'd1;
      end
      if (strb.wbMode) begin
        complR <= 32'(baseAddr);
        live   <= 1'b0;
      end else if (strb.tdMode) begin
        complR <= TEAR_SENTINEL;
        live   <= 1'b0;
      end else if (complWrEn) begin
        complR <= complWrData;
      end
    end
  end

  assign complPtr  = complR;
  assign xferValid = strb.xferStep;
  assign xferPtr   = ptrR;
  assign headPend  = headR;

  // R5: every mode word handed back to software has ownership released
  p_owner_rel_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> !memWdata[OWN_BIT]);

  // R4: consecutive byte steps advance the buffer address by one
  p_byte_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && $past(xferValid)) |-> (xferPtr == $past(xferPtr) + 32'd1));

  // R2: a fetch read is followed by the next read until the mode word is read
  p_read_burst_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && memAddr[3:2] != 2'b11) |=> (memReq && !memWe));

endmodule

// File: rtl/ldesc_channel.sv
module ldesc_channel
  import ldesc_pkg::*;
#(
  parameter int AW   = 16,
  parameter int LENW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          headWrEn,
  input  logic [31:0]   headWrData,
  input  logic          complWrEn,
  input  logic [31:0]   complWrData,
  input  logic          tearReq,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata,
  output logic [31:0]   complPtr,
  output logic          xferValid,
  output logic [31:0]   xferPtr,
  output logic          doneEvt,
  output logic          busy
);

  chStrb_t strb;
  logic    headPend, fetchDone, ownerNow, remZero, nextZero;

  ldesc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .tearReq   (tearReq),
    .headPend  (headPend),
    .fetchDone (fetchDone),
    .ownerNow  (ownerNow),
    .remZero   (remZero),
    .nextZero  (nextZero),
    .strb      (strb),
    .busy      (busy),
    .doneEvt   (doneEvt)
  );

  ldesc_dpath #(.AW(AW), .LENW(LENW)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .busy        (busy),
    .headWrEn    (headWrEn),
    .headWrData  (headWrData),
    .complWrEn   (complWrEn),
    .complWrData (complWrData),
    .memRdata    (memRdata),
    .memReq      (memReq),
    .memWe       (memWe),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .complPtr    (complPtr),
    .xferValid   (xferValid),
    .xferPtr     (xferPtr),
    .headPend    (headPend),
    .fetchDone   (fetchDone),
    .ownerNow    (ownerNow),
    .remZero     (remZero),
    .nextZero    (nextZero)
  );

  // R5: the completion event follows a descriptor write by one cycle
  p_evt_after_wb_r5: assert property (@(posedge clk) disable iff (!rstN)
    doneEvt |-> $past(memReq && memWe));

  // R1: an idle channel leaves the descriptor RAM alone
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

endmodule

// File: tb/test_ldesc_channel.sv
`timescale 1ns/1ps
module test_ldesc_channel;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enable = 1'b0;
  logic          headWrEn = 1'b0;
  logic [31:0]   headWrData = '0;
  logic          complWrEn = 1'b0;
  logic [31:0]   complWrData = '0;
  logic          tearReq = 1'b0;
  logic          memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [31:0]   memWdata;
  logic [31:0]   memRdata = '0;
  logic [31:0]   complPtr;
  logic          xferValid;
  logic [31:0]   xferPtr;
  logic          doneEvt, busy;

  always #4 clk = ~clk;

  ldesc_channel #(.AW(AW)) i_ldesc_channel (
    .clk(clk), .rstN(rstN), .enable(enable),
    .headWrEn(headWrEn), .headWrData(headWrData),
    .complWrEn(complWrEn), .complWrData(complWrData),
    .tearReq(tearReq),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata),
    .complPtr(complPtr), .xferValid(xferValid), .xferPtr(xferPtr),
    .doneEvt(doneEvt), .busy(busy)
  );

  logic [31:0] mem [64];
  always @(posedge clk) begin
    if (memReq) begin
      if (memWe) mem[memAddr[7:2]] <= memWdata;
      else       memRdata <= mem[memAddr[7:2]];
    end
  end

  int nChk = 0;
  int nBad = 0;
  int evtCnt = 0;
  int wrCnt = 0;
  logic [31:0] expA[$];
  logic [31:0] expD[$];
  logic [31:0] readLog[$];
  logic [31:0] xferLog[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: scoreboard of descriptor writes plus logs of reads and byte steps
  always @(negedge clk) begin
    if (rstN) begin
      if (xferValid) xferLog.push_back(xferPtr);
      if (doneEvt) evtCnt++;
      if (memReq && !memWe) readLog.push_back(32'(memAddr));
      if (memReq && memWe) begin
        wrCnt++;
        if (expA.size() == 0) begin
          chk("R5 unexpected write addr", 32'(memAddr), 32'hFFFF_FFFF);
        end else begin
          chk("R5 writeback addr", 32'(memAddr), expA.pop_front());
          chk("R5 writeback data", memWdata, expD.pop_front());
        end
      end
    end
  end

  task automatic setDesc(input int a, input logic [31:0] nxt, input logic [31:0] buff,
                         input logic [31:0] len, input logic [31:0] mode);
    mem[(a >> 2) + 0] = nxt;
    mem[(a >> 2) + 1] = buff;
    mem[(a >> 2) + 2] = len;
    mem[(a >> 2) + 3] = mode;
  endtask

  task automatic expectWb(input logic [31:0] a, input logic [31:0] d);
    expA.push_back(a);
    expD.push_back(d);
  endtask

  task automatic writeHead(input logic [31:0] v);
    @(negedge clk); headWrEn = 1'b1; headWrData = v;
    @(negedge clk); headWrEn = 1'b0;
  endtask

  task automatic writeCompl(input logic [31:0] v);
    @(negedge clk); complWrEn = 1'b1; complWrData = v;
    @(negedge clk); complWrEn = 1'b0;
  endtask

  task automatic pulseTear();
    @(negedge clk); tearReq = 1'b1;
    @(negedge clk); tearReq = 1'b0;
  endtask

  task automatic waitIdle();
    repeat (4) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int evt0, wr0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 complPtr", complPtr, 0);
    chk("R1 doneEvt", 32'(doneEvt), 0);
    chk("R1 memReq", 32'(memReq), 0);

    // single descriptor, length 5, null next pointer
    enable = 1'b1;
    setDesc(32'h40, 0, 32'h1000, 5, 32'hE000_0005);
    readLog.delete(); xferLog.delete(); evt0 = evtCnt;
    expectWb(32'h4C, 32'hD000_0005);
    writeHead(32'h40);
    waitIdle();
    chk("R2 read count", readLog.size(), 4);
    if (readLog.size() == 4) begin
      chk("R2 read 0", readLog[0], 32'h40);
      chk("R2 read 1", readLog[1], 32'h44);
      chk("R2 read 2", readLog[2], 32'h48);
      chk("R2 read 3", readLog[3], 32'h4C);
    end
    chk("R4 byte count", xferLog.size(), 5);
    if (xferLog.size() == 5) begin
      chk("R4 first ptr", xferLog[0], 32'h1000);
      chk("R4 last ptr", xferLog[4], 32'h1004);
    end
    chk("R5 complPtr", complPtr, 32'h40);
    chk("R5 doneEvt count", evtCnt - evt0, 1);
    chk("R6 end-of-queue in mem", mem[32'h4C >> 2], 32'hD000_0005);

    // R10: software acknowledge
    writeCompl(32'h0000_1234);
    chk("R10 complPtr", complPtr, 32'h0000_1234);

    // chain of three, middle one zero length; head write while busy
    setDesc(32'h40, 32'h60, 32'h2000, 3, 32'hE000_0003);
    setDesc(32'h60, 32'h80, 32'h3000, 0, 32'hE000_0000);
    setDesc(32'h80, 0,      32'h4000, 2, 32'hE000_0002);
    setDesc(32'hA0, 0,      32'h5000, 1, 32'hE000_0001);
    expectWb(32'h4C, 32'hC000_0003);
    expectWb(32'h6C, 32'hC000_0000);
    expectWb(32'h8C, 32'hD000_0002);
    xferLog.delete(); evt0 = evtCnt;
    writeHead(32'h40);
    repeat (2) @(negedge clk);
    writeHead(32'hA0);
    waitIdle();
    chk("R6 chain events", evtCnt - evt0, 3);
    chk("R6 final complPtr", complPtr, 32'h80);
    chk("R12 byte count over chain", xferLog.size(), 5);
    if (xferLog.size() == 5) chk("R12 third desc first ptr", xferLog[3], 32'h4000);
    chk("R12 zero-length writeback", mem[32'h6C >> 2], 32'hC000_0000);
    repeat (20) @(negedge clk);
    chk("R11 stays idle", 32'(busy), 0);
    chk("R11 bait untouched", mem[32'hAC >> 2], 32'hE000_0001);
    chk("R11 no extra events", evtCnt - evt0, 3);

    // R3: enable gate
    enable = 1'b0;
    setDesc(32'h40, 0, 32'h6000, 2, 32'hE000_0002);
    readLog.delete(); evt0 = evtCnt;
    writeHead(32'h40);
    repeat (10) @(negedge clk);
    chk("R3 idle while disabled", 32'(busy), 0);
    chk("R3 no reads while disabled", readLog.size(), 0);
    expectWb(32'h4C, 32'hD000_0002);
    enable = 1'b1;
    waitIdle();
    chk("R3 runs after enable", evtCnt - evt0, 1);
    chk("R3 reads after enable", readLog.size(), 4);

    // R7: owner already clear
    setDesc(32'h60, 0, 32'h7000, 4, 32'hC000_0004);
    readLog.delete(); xferLog.delete(); evt0 = evtCnt; wr0 = wrCnt;
    writeHead(32'h60);
    waitIdle();
    chk("R7 fetched", readLog.size(), 4);
    chk("R7 no write", wrCnt - wr0, 0);
    chk("R7 no event", evtCnt - evt0, 0);
    chk("R7 no bytes", xferLog.size(), 0);
    chk("R7 mode kept", mem[32'h6C >> 2], 32'hC000_0004);

    // R8: teardown during stepping
    setDesc(32'h40, 0, 32'h8000, 200, 32'h2000_00C8);
    expectWb(32'h4C, 32'h0800_00C8);
    xferLog.delete(); evt0 = evtCnt;
    writeHead(32'h40);
    repeat (20) @(negedge clk);
    pulseTear();
    waitIdle();
    chk("R8 complPtr sentinel", complPtr, 32'hFFFF_FFFC);
    chk("R8 stepping cut short", 32'((xferLog.size() > 0) && (xferLog.size() < 200)), 1);
    chk("R8 teardown mode in mem", mem[32'h4C >> 2], 32'h0800_00C8);
    chk("R8 no done event", evtCnt - evt0, 0);
    repeat (10) @(negedge clk);
    chk("R8 head dropped", 32'(busy), 0);

    // R9: teardown while idle
    writeCompl(32'h0);
    chk("R10 cleared", complPtr, 32'h0);
    wr0 = wrCnt;
    pulseTear();
    repeat (4) @(negedge clk);
    chk("R9 complPtr sentinel", complPtr, 32'hFFFF_FFFC);
    chk("R9 no write", wrCnt - wr0, 0);
    chk("R9 idle", 32'(busy), 0);

    // R2: zero head write cancels a pending start
    enable = 1'b0;
    setDesc(32'h40, 0, 32'h9000, 1, 32'hE000_0001);
    readLog.delete();
    writeHead(32'h40);
    writeHead(32'h0);
    enable = 1'b1;
    repeat (10) @(negedge clk);
    chk("R2 zero head leaves idle", 32'(busy), 0);
    chk("R2 zero head no reads", readLog.size(), 0);

    chk("R5 scoreboard drained", expA.size(), 0);
    summary();
    $finish;
  end

endmodule